// File: doc/BRIEF.md
# Configuration Save and Restore Controller

This block keeps a small set of configuration registers and can copy selected bits of them into a modelled nonvolatile store. Later, on a device reset request, it puts them back. The host reaches the registers through a simple write port and a combinational read port. Each write carries a strobe that says whether the write arrived with a valid CRC. The serial framing and the CRC arithmetic live outside the block. The block only exports the CRC enable bit and the polynomial select bit that it holds.

A save is armed by one guarded write to the command register. It then walks the register table one entry at a time, and each entry costs a fixed number of write cycles. When all entries are stored, the progress bit clears itself. Every completed save counts as one programming cycle, and the block refuses saves once the endurance limit is reached.

A reset request first returns every table register to its default value. It then overlays the kept bits from the store, one entry per cycle. When the last entry is loaded, the block pulses a restart indication.

Top module: `cfg_keep`

## Requirements
- R1: A write to address 8'h4E with bit 7 = 1 and bits 3:0 = 4'hA starts a save and raises busy on the next cycle. The write must have crc_ok high, it must arrive while the CRC enable bit (bit 0 of 8'h0A) is 1, and the cycle count must be below MAX_CYC (500).
- R2: A write to 8'h4E with bit 7 = 1 that has a wrong key nibble, crc_ok low, or CRC enable 0 is discarded. It leaves the store and wr_cycles unchanged and sets cmd_err, which stays high until rst_n. A write to 8'h4E with bit 7 = 0 does nothing.
- R3: Bit 0 of 8'h0A drives crc_chk_en and bit 0 of 8'h0B drives crc_poly (0 = AUTOSAR polynomial, 1 = SAE J1850 polynomial). Bits 7:1 of both registers read as 0.
- R4: Reading 8'h4E returns bits 6:0 = 0 at all times, and bit 7 = 1 exactly while a save is in progress.
- R5: A save keeps busy high for NREG*WR_LAT cycles (6*4 = 24) after the command edge and then clears by itself. wr_cycles increases by exactly 1 per completed save.
- R6: Each table register stores only its kept bits. The table gives address, kept-bit mask and reset default: 09h/0F/A0, 0Ch/53/24, 13h/FF/00, 16h/F0/05, 29h/20/11, 2Dh/FF/00. The registers are read and written as full bytes. Any unmapped address reads 0.
- R7: Once wr_cycles equals 500, a further valid command starts no save, does not set cmd_err, and leaves wr_cycles at 500.
- R8: rst_req seen while idle does four things. It sets every table register to its default and clears 8'h0A and 8'h0B. It then loads each entry as (default & ~mask) | (stored & mask), one entry per cycle, with busy high for NREG cycles. Finally it gives a one-cycle restart pulse in the first cycle that busy is low again.
- R9: Host writes are rejected while busy. A rst_req seen while busy is ignored. A rst_req in the same cycle as a host write wins, and the write is dropped.
- R10: After rst_n, the table registers hold their defaults and the store holds 0. wr_cycles, busy, cmd_err, restart, crc_chk_en and crc_poly are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| crc_ok | input | 1 | CRC of this write frame matched |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| rst_req | input | 1 | Device reset request, triggers restore |
| busy | output | 1 | Save or restore in progress |
| restart | output | 1 | One-cycle pulse after a restore completes |
| cmd_err | output | 1 | Sticky rejected-command flag |
| crc_chk_en | output | 1 | CRC checking enabled |
| crc_poly | output | 1 | Polynomial select, 1 = SAE J1850 |
| wr_cycles | output | CYC_W (9) | Completed save count |

## Verification
The assertions assume three things about the inputs. rd_addr is a plain address that is sampled combinationally. crc_ok matters only in the cycle that wr_en is high. rst_n is the only source of reset, and it is held for at least one edge. The stimulus changes every input just after a rising edge and holds it for one whole cycle. Commands, register writes and reset requests are issued as single-cycle pulses, and some are deliberately placed inside busy windows to probe rejection.

// File: rtl/cfg_keep_pkg.sv
package cfg_keep_pkg;

  localparam int NREG = 6;
  localparam logic [7:0] CMD_ADDR   = 8'h4E;
  localparam logic [7:0] CRCEN_ADDR = 8'h0A;
  localparam logic [7:0] POLY_ADDR  = 8'h0B;
  localparam logic [3:0] CMD_KEY    = 4'hA;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD} seq_st_t;

  function automatic logic [7:0] ent_addr(input int i);
    case (i)
      0: return 8'h09;
      1: return 8'h0C;
      2: return 8'h13;
      3: return 8'h16;
      4: return 8'h29;
      default: return 8'h2D;
    endcase
  endfunction

  function automatic logic [7:0] ent_mask(input int i);
    case (i)
      0: return 8'h0F;
      1: return 8'h53;
      2: return 8'hFF;
      3: return 8'hF0;
      4: return 8'h20;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] ent_dflt(input int i);
    case (i)
      0: return 8'hA0;
      1: return 8'h24;
      3: return 8'h05;
      4: return 8'h11;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_keep_cmd.sv
module cfg_keep_cmd
  import cfg_keep_pkg::*;
#(
  parameter int MAX_CYC = 500,
  parameter int CYC_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic             go_bit,
  input  logic [3:0]       key,
  input  logic             crc_ok,
  input  logic             crc_en,
  input  logic             idle,
  input  logic             rst_req,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             start_save,
  output logic             err_q
);

  logic hit, good, room, err_set;

  always_comb begin
    hit        = wr_en & idle & ~rst_req & (wr_addr == CMD_ADDR) & go_bit;
    good       = (key == CMD_KEY) & crc_en & crc_ok;
    room       = cyc_cnt < CYC_W'(MAX_CYC);
    start_save = hit & good & room;
    err_set    = hit & ~good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

endmodule

// File: rtl/cfg_keep_seq.sv
module cfg_keep_seq
  import cfg_keep_pkg::*;
#(
  parameter int WR_LAT  = 4,
  parameter int MAX_CYC = 500,
  parameter int CYC_W   = 9,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_save,
  input  logic             rst_req,
  output logic             idle,
  output logic             save_act,
  output logic             ld_start,
  output logic             ld_we,
  output logic             nv_we,
  output logic [IDX_W-1:0] idx,
  output logic             restart,
  output logic [CYC_W-1:0] cyc_cnt
);

  localparam int LAT_W = $clog2(WR_LAT + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  seq_st_t          state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             rs_q, rs_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    lat_d    = lat_q;
    cyc_d    = cyc_q;
    nv_we    = 1'b0;
    ld_we    = 1'b0;
    ld_start = 1'b0;
    rs_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_save) begin
          state_d = ST_SAVE;
          idx_d   = '0;
          lat_d   = '0;
        end else if (rst_req) begin
          ld_start = 1'b1;
          state_d  = ST_LOAD;
          idx_d    = '0;
        end
      end
      ST_SAVE: begin
        if (lat_q == LAT_W'(WR_LAT - 1)) begin
          nv_we = 1'b1;
          lat_d = '0;
          if (idx_q == LAST) begin
            state_d = ST_IDLE;
            cyc_d   = cyc_q + 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      ST_LOAD: begin
        ld_we = 1'b1;
        if (idx_q == LAST) begin
          state_d = ST_IDLE;
          rs_d    = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lat_q   <= '0;
      cyc_q   <= '0;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      lat_q   <= lat_d;
      cyc_q   <= cyc_d;
      rs_q    <= rs_d;
    end
  end

  assign idle     = (state_q == ST_IDLE);
  assign save_act = (state_q == ST_SAVE);
  assign idx      = idx_q;
  assign restart  = rs_q;
  assign cyc_cnt  = cyc_q;

endmodule

// File: rtl/cfg_keep_regs.sv
module cfg_keep_regs
  import cfg_keep_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             ld_start,
  input  logic             ld_we,
  input  logic             nv_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_word,
  output logic             crc_en,
  output logic             poly
);

  logic [NREG-1:0][7:0] val_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    localparam logic [7:0] A = ent_addr(g);
    localparam logic [7:0] M = ent_mask(g);
    localparam logic [7:0] D = ent_dflt(g);
    logic [7:0] val_q, val_d, nv_q;
    logic       sel;

    assign sel = (idx == IDX_W'(g));

    always_comb begin
      val_d = val_q;
      if (ld_start)                           val_d = D;
      else if (ld_we && sel)                  val_d = (D & ~M) | (nv_q & M);
      else if (host_we && (wr_addr == A))     val_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= D;
      else        val_q <= val_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            nv_q <= '0;
      else if (nv_we && sel) nv_q <= val_q & M;
    end

    assign val_vec[g] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_en <= 1'b0;
      poly   <= 1'b0;
    end else if (ld_start) begin
      crc_en <= 1'b0;
      poly   <= 1'b0;
    end else if (host_we) begin
      if (wr_addr == CRCEN_ADDR) crc_en <= wr_data[0];
      if (wr_addr == POLY_ADDR)  poly   <= wr_data[0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == CRCEN_ADDR) rd_word = {7'b0, crc_en};
    if (rd_addr == POLY_ADDR)  rd_word = {7'b0, poly};
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == ent_addr(i)) rd_word = val_vec[i];
    end
  end

endmodule

// File: rtl/cfg_keep.sv
module cfg_keep
  import cfg_keep_pkg::*;
#(
  parameter int WR_LAT  = 4,
  parameter int MAX_CYC = 500,
  parameter int CYC_W   = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             crc_ok,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             rst_req,
  output logic             busy,
  output logic             restart,
  output logic             cmd_err,
  output logic             crc_chk_en,
  output logic             crc_poly,
  output logic [CYC_W-1:0] wr_cycles
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic             idle, save_act, ld_start, ld_we, nv_we, start_save, host_we;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rd_word;

  assign host_we = wr_en & idle & ~rst_req & (wr_addr != CMD_ADDR);

  cfg_keep_cmd #(.MAX_CYC(MAX_CYC), .CYC_W(CYC_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .go_bit(wr_data[7]), .key(wr_data[3:0]), .crc_ok(crc_ok),
    .crc_en(crc_chk_en), .idle(idle), .rst_req(rst_req),
    .cyc_cnt(wr_cycles), .start_save(start_save), .err_q(cmd_err)
  );

  cfg_keep_seq #(.WR_LAT(WR_LAT), .MAX_CYC(MAX_CYC), .CYC_W(CYC_W), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_save(start_save), .rst_req(rst_req),
    .idle(idle), .save_act(save_act), .ld_start(ld_start), .ld_we(ld_we),
    .nv_we(nv_we), .idx(idx), .restart(restart), .cyc_cnt(wr_cycles)
  );

  cfg_keep_regs #(.IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_start(ld_start), .ld_we(ld_we), .nv_we(nv_we),
    .idx(idx), .rd_addr(rd_addr), .rd_word(rd_word),
    .crc_en(crc_chk_en), .poly(crc_poly)
  );

  assign busy    = ~idle;
  assign rd_data = (rd_addr == CMD_ADDR) ? {save_act, 7'b0} : rd_word;

endmodule

// File: rtl/cfg_keep_chk.sv
module cfg_keep_chk #(
  parameter int MAX_CYC = 500,
  parameter int CYC_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             crc_ok,
  input logic [7:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic             rst_req,
  input logic             busy,
  input logic             restart,
  input logic             cmd_err,
  input logic             crc_chk_en,
  input logic [CYC_W-1:0] wr_cycles
);

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !rst_req && wr_addr == 8'h4E && wr_data[7] &&
     wr_data[3:0] == 4'hA && crc_ok && crc_chk_en && wr_cycles < CYC_W'(MAX_CYC))
    |=> busy);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  p_key_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'h4E) |-> (rd_data[6:0] == 7'd0));

  p_idle_cmd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'h4E && !busy) |-> (rd_data == 8'd0));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_cycles == $past(wr_cycles) || wr_cycles == $past(wr_cycles) + 1'b1));

  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cycles <= CYC_W'(MAX_CYC));

  p_restart_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> ($past(busy) && !busy));

  p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  p_busy_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(crc_chk_en));

endmodule

bind cfg_keep cfg_keep_chk #(.MAX_CYC(MAX_CYC), .CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .crc_ok(crc_ok), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req),
  .busy(busy), .restart(restart), .cmd_err(cmd_err), .crc_chk_en(crc_chk_en),
  .wr_cycles(wr_cycles)
);

// File: tb/cfg_keep_tb_top.sv
module cfg_keep_tb_top;

  localparam int NE = 6;
  localparam int WL = 4;
  localparam int LIM = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, crc_ok = 1'b0, rst_req = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       busy, restart, cmd_err, crc_chk_en, crc_poly;
  logic [8:0] wr_cycles;

  int n_chk = 0, n_bad = 0, sweep = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_keep dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .crc_ok(crc_ok), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req),
    .busy(busy), .restart(restart), .cmd_err(cmd_err), .crc_chk_en(crc_chk_en),
    .crc_poly(crc_poly), .wr_cycles(wr_cycles)
  );

  // specification table (R6)
  logic [7:0] t_adr [NE] = '{8'h09, 8'h0C, 8'h13, 8'h16, 8'h29, 8'h2D};
  logic [7:0] t_msk [NE] = '{8'h0F, 8'h53, 8'hFF, 8'hF0, 8'h20, 8'hFF};
  logic [7:0] t_def [NE] = '{8'hA0, 8'h24, 8'h00, 8'h05, 8'h11, 8'h00};
  logic [7:0] sw_list [10] = '{8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h13, 8'h16, 8'h29, 8'h2D, 8'h4E, 8'h55};

  // behavioural reference model
  logic [7:0] m_reg [NE];
  logic [7:0] m_nv [NE];
  int m_mode, m_left, m_cyc;
  bit m_err, m_rs, m_crc, m_poly;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h4E) return {(m_mode == 1), 7'b0};
    if (a == 8'h0A) return {7'b0, m_crc};
    if (a == 8'h0B) return {7'b0, m_poly};
    for (int i = 0; i < NE; i++) if (t_adr[i] == a) return m_reg[i];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin m_reg[i] = t_def[i]; m_nv[i] = 8'h00; end
      m_mode = 0; m_left = 0; m_cyc = 0; m_err = 0; m_rs = 0; m_crc = 0; m_poly = 0;
    end else begin
      m_rs = 0;
      if (m_mode == 0) begin
        if (rst_req) begin
          for (int i = 0; i < NE; i++) m_reg[i] = t_def[i];
          m_crc = 0; m_poly = 0; m_mode = 2; m_left = NE;
        end else if (wr_en) begin
          if (wr_addr == 8'h4E) begin
            if (wr_data[7]) begin
              if (wr_data[3:0] == 4'hA && m_crc && crc_ok) begin
                if (m_cyc < LIM) begin m_mode = 1; m_left = NE * WL; end
              end else m_err = 1;
            end
          end else if (wr_addr == 8'h0A) m_crc = wr_data[0];
          else if (wr_addr == 8'h0B) m_poly = wr_data[0];
          else for (int i = 0; i < NE; i++) if (t_adr[i] == wr_addr) m_reg[i] = wr_data;
        end
      end else if (m_mode == 1) begin
        m_left--;
        if (m_left == 0) begin
          for (int i = 0; i < NE; i++) m_nv[i] = m_reg[i] & t_msk[i];
          m_cyc++; m_mode = 0;
        end
      end else begin
        m_reg[NE - m_left] = (t_def[NE - m_left] & ~t_msk[NE - m_left]) |
                             (m_nv[NE - m_left] & t_msk[NE - m_left]);
        m_left--;
        if (m_left == 0) begin m_mode = 0; m_rs = 1; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 busy", busy, (m_mode != 0));
      chk("R2 cmd_err", cmd_err, m_err);
      chk("R5 wr_cycles", wr_cycles, m_cyc);
      chk("R8 restart", restart, m_rs);
      chk("R3 crc_chk_en", crc_chk_en, m_crc);
      chk("R3 crc_poly", crc_poly, m_poly);
      chk("R6 rd_data", rd_data, m_read(rd_addr));
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    wr_en = 0; rst_req = 0; crc_ok = 0;
    rd_addr = sw_list[sweep % 10]; sweep++;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit ok);
    cyc();
    wr_en = 1; wr_addr = a; wr_data = d; crc_ok = ok;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    cyc();
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    cyc();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!busy) break;
      cyc();
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; wr_en = 0; rst_req = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    rdchk("R10 def 09", 8'h09, 8'hA0);
    rdchk("R10 def 0C", 8'h0C, 8'h24);
    rdchk("R10 def 16", 8'h16, 8'h05);
    rdchk("R10 unmapped", 8'h55, 8'h00);
    chk("R10 busy", busy, 0);
    chk("R10 wr_cycles", wr_cycles, 0);

    // R3 polynomial and enable
    wr(8'h0B, 8'hFF, 1);
    cyc(); @(negedge clk); chk("R3 poly", crc_poly, 1);
    rdchk("R3 0B readback", 8'h0B, 8'h01);

    // R2 wrong key
    wr(8'h0A, 8'h01, 1);
    wr(8'h4E, 8'h85, 1);
    cyc(); @(negedge clk);
    chk("R2 bad key err", cmd_err, 1); chk("R2 bad key busy", busy, 0);
    do_reset();
    // R2 CRC mismatch
    wr(8'h0A, 8'h01, 1);
    wr(8'h4E, 8'h8A, 0);
    cyc(); @(negedge clk);
    chk("R2 crc mismatch err", cmd_err, 1); chk("R2 crc mismatch cnt", wr_cycles, 0);
    do_reset();
    // R2 CRC disabled, and bit7=0 write
    wr(8'h4E, 8'h0A, 1);
    cyc(); @(negedge clk); chk("R2 no go bit", cmd_err, 0);
    wr(8'h4E, 8'h8A, 1);
    cyc(); @(negedge clk);
    chk("R2 crc off err", cmd_err, 1); chk("R2 crc off busy", busy, 0);
    do_reset();

    // valid save
    wr(8'h0A, 8'h01, 1);
    wr(8'h0B, 8'h01, 1);
    wr(8'h09, 8'h5C, 1); wr(8'h0C, 8'hFF, 1); wr(8'h13, 8'h3C, 1);
    wr(8'h16, 8'h9A, 1); wr(8'h29, 8'hFF, 1); wr(8'h2D, 8'hC3, 1);
    wr(8'h4E, 8'h8A, 1);
    cyc(); @(negedge clk); chk("R1 busy after cmd", busy, 1);
    rdchk("R4 progress bit", 8'h4E, 8'h80);
    wr(8'h09, 8'h00, 1);            // R9 rejected while busy
    cyc(); rst_req = 1;             // R9 ignored while busy
    wait_idle();
    chk("R5 count after save", wr_cycles, 1);
    rdchk("R9 write rejected", 8'h09, 8'h5C);
    rdchk("R4 idle readback", 8'h4E, 8'h00);

    // R8 restore
    wr(8'h09, 8'hFF, 1); wr(8'h0C, 8'h00, 1); wr(8'h13, 8'h00, 1);
    wr(8'h16, 8'h00, 1); wr(8'h29, 8'h00, 1); wr(8'h2D, 8'h00, 1);
    cyc(); rst_req = 1;
    wait_idle();
    chk("R8 restart pulse", restart, 1);
    rdchk("R8 09", 8'h09, 8'hAC);
    rdchk("R8 0C", 8'h0C, 8'h77);
    rdchk("R8 13", 8'h13, 8'h3C);
    rdchk("R8 16", 8'h16, 8'h95);
    rdchk("R8 29", 8'h29, 8'h31);
    rdchk("R8 2D", 8'h2D, 8'hC3);
    rdchk("R8 0A cleared", 8'h0A, 8'h00);

    // R9 rst_req beats same-cycle write
    cyc(); rst_req = 1; wr_en = 1; wr_addr = 8'h13; wr_data = 8'h55;
    wait_idle();
    rdchk("R9 reset wins", 8'h13, 8'h3C);

    // R7 endurance
    do_reset();
    wr(8'h0A, 8'h01, 1);
    for (int i = 0; i < LIM; i++) begin
      wr(8'h4E, 8'h8A, 1);
      wait_idle();
    end
    chk("R7 at limit", wr_cycles, LIM);
    wr(8'h4E, 8'h8A, 1);
    cyc(); @(negedge clk);
    chk("R7 no save", busy, 0);
    chk("R7 no err", cmd_err, 0);
    chk("R7 count held", wr_cycles, LIM);

    cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule